// File: doc/BRIEF.md
# Delimiter Timestamp Capture and Drift-Trimmed Cycle Timer

This block keeps a free-running nanosecond timer for a node on a ring-type industrial fieldbus and timestamps incoming frames. Each of its receive ports delivers one byte per clock with a valid strobe. A port hunts for the start-of-frame delimiter, which is the byte 0xD5 after a run of 0x55 preamble bytes. When the delimiter arrives, the port stores the current timer value in its own capture slot. Each slot keeps its first value until it is cleared, and it flags any later arrival that could not be stored.

The control side writes the arrival time that it expected in the current cycle and picks which port's capture to compare against. One clock later the block presents the signed difference, captured minus expected. A positive result means the frame arrived late, so the local timer is running fast and has to be slowed.

Drift is removed without loading a new time. The controller loads a tick count, and for exactly that many clocks the timer advances by a programmable alternate step instead of its normal step. When the count runs out, the normal step returns by itself. The timer wraps modulo a programmable cycle period and marks each wrap with a one-clock pulse.

Top module: `sfd_ts_sync`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls: `now_ns`=0, `cycle_start`=0, `comp_busy`=0, `offset_valid`=0, and every bit of `cap_full` and `cap_overrun` is 0.
- R2: With no compensation pending, `now_ns` advances by NORM_STEP (5) on every clock. When the sum reaches or passes `cfg_period`, the period is subtracted from it. `cycle_start` is high for exactly the clock in which the wrapped value is shown.
- R3: A clock edge that sees `comp_load` high loads `comp_ticks` into the pending count. That edge still uses the step chosen by the old count. Each of the next N edges steps by `cfg_alt_step` (0 to 15) and decrements the count, and then the normal step resumes. `comp_busy` is high while the count is nonzero. A new load while busy restarts the count.
- R4: On port p, with `rx_valid[p]` held high, the first byte is 0x55, any further 0x55 bytes follow, and the next byte is 0xD5. That delimiter stores into slot p the `now_ns` value shown during the clock in which the delimiter byte is presented. For example, the delimiter is byte index 2 after two preamble bytes.
- R5: A frame whose first byte is not 0x55, or whose first non-0x55 byte is not 0xD5, causes no capture. All later bytes of that frame are ignored, including 0xD5. Only the first delimiter of a frame captures. The hunt restarts only after `rx_valid[p]` goes low.
- R6: Ports are independent. A capture, clear or overrun on one port leaves the other port's slot, full flag and overrun flag unchanged.
- R7: `cap_full[p]` is set by a capture and cleared by `cap_clear[p]`. If a clear and a delimiter arrive in the same clock, the new value is stored, `cap_full[p]` stays 1 and `cap_overrun[p]` is 0.
- R8: A delimiter that arrives while slot p is full and not being cleared sets `cap_overrun[p]` and leaves `cap_ns` for p unchanged. `cap_clear[p]` clears the overrun flag.
- R9: A clock with `exp_wr` high makes `offset_valid` high in the next clock only. In that clock, `offset_ns` = slot[`off_port`] − `exp_time` as a signed 32-bit value (for example, 2550 captured and 2500 expected gives +50). `offset_ns` holds this value until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (one tick per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | TW | Cycle period in ns; timer wraps modulo this value |
| cfg_alt_step | input | SW | Alternate increment used while compensation is pending |
| comp_load | input | 1 | Load `comp_ticks` into the pending compensation count |
| comp_ticks | input | CW | Number of ticks to apply the alternate increment |
| rx_valid | input | NP | Per-port receive byte valid |
| rx_byte | input | 8*NP | Per-port receive byte, port p at bits [8p+7:8p] |
| cap_clear | input | NP | Per-port read acknowledge; clears full and overrun flags |
| off_port | input | PW | Port whose capture feeds the offset computation |
| exp_wr | input | 1 | Strobe: expected arrival time is present |
| exp_time | input | TW | Expected arrival time within the cycle, ns |
| now_ns | output | TW | Current timer value |
| cycle_start | output | 1 | One-clock pulse when the timer wraps |
| comp_busy | output | 1 | Compensation ticks remain |
| cap_ns | output | TW*NP | Per-port captured time, port p at bits [TW*p+TW-1:TW*p] |
| cap_full | output | NP | Per-port sticky capture-held flag |
| cap_overrun | output | NP | Per-port flag: a delimiter arrived while full |
| offset_ns | output | OW | Signed captured-minus-expected offset |
| offset_valid | output | 1 | One-clock strobe marking a fresh offset |

## Verification
A wrong hunt state shows up at the end of the frame as a missing or spurious `cap_full` bit, or as a `cap_ns` value that is off by whole steps. A wrong timer step or count shows up in `now_ns` on the very next clock, because the timer is compared against an arithmetic model on every cycle. The same comparison runs during compensation windows for every alternate step from 0 to 15. A corrupted capture slot or overrun path is exposed within one frame of the second delimiter, and a bad offset path is exposed in the clock after `exp_wr`.

// File: rtl/sfd_ts_pkg.sv
package sfd_ts_pkg;
  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  typedef enum logic [1:0] {
    HUNT_IDLE,
    HUNT_PRE,
    HUNT_DONE
  } hunt_e;
endpackage

// File: rtl/sfd_hunt.sv
module sfd_hunt
  import sfd_ts_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       sfd_hit
);
  hunt_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    sfd_hit = 1'b0;
    if (!rx_valid) begin
      st_d = HUNT_IDLE;
    end else begin
      case (st_q)
        HUNT_IDLE: st_d = (rx_byte == PRE_BYTE) ? HUNT_PRE : HUNT_DONE;
        HUNT_PRE: begin
          if (rx_byte == SFD_BYTE) begin
            sfd_hit = 1'b1;
            st_d    = HUNT_DONE;
          end else if (rx_byte != PRE_BYTE) begin
            st_d = HUNT_DONE;
          end
        end
        default: st_d = HUNT_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= HUNT_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          clear,
  input  logic [TW-1:0] now,
  output logic [TW-1:0] cap_q,
  output logic          full_q,
  output logic          ovr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (clear) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (hit) begin
        if (full_q && !clear) begin
          ovr_q <= 1'b1;
        end else begin
          cap_q  <= now;
          full_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/drift_timer.sv
module drift_timer #(
  parameter int TW   = 32,
  parameter int SW   = 4,
  parameter int CW   = 16,
  parameter int NORM = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] period,
  input  logic [SW-1:0] alt_step,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  output logic [TW-1:0] now_q,
  output logic          wrap_q,
  output logic          busy
);
  logic [CW-1:0] cnt_q;
  logic [TW:0]   step, sum, nxt;
  logic          wrap;

  assign busy = (cnt_q != '0);

  always_comb begin
    step = busy ? (TW+1)'(alt_step) : (TW+1)'(NORM);
    sum  = {1'b0, now_q} + step;
    wrap = (sum >= {1'b0, period});
    nxt  = wrap ? (sum - {1'b0, period}) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q  <= '0;
      wrap_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      now_q  <= nxt[TW-1:0];
      wrap_q <= wrap;
      if (load)      cnt_q <= load_cnt;
      else if (busy) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sfd_ts_sync.sv
module sfd_ts_sync #(
  parameter int NP        = 2,
  parameter int TW        = 32,
  parameter int SW        = 4,
  parameter int CW        = 16,
  parameter int OW        = 32,
  parameter int NORM_STEP = 5,
  localparam int PW       = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   cfg_period,
  input  logic [SW-1:0]   cfg_alt_step,
  input  logic            comp_load,
  input  logic [CW-1:0]   comp_ticks,
  input  logic [NP-1:0]   rx_valid,
  input  logic [8*NP-1:0] rx_byte,
  input  logic [NP-1:0]   cap_clear,
  input  logic [PW-1:0]   off_port,
  input  logic            exp_wr,
  input  logic [TW-1:0]   exp_time,
  output logic [TW-1:0]   now_ns,
  output logic            cycle_start,
  output logic            comp_busy,
  output logic [TW*NP-1:0] cap_ns,
  output logic [NP-1:0]   cap_full,
  output logic [NP-1:0]   cap_overrun,
  output logic [OW-1:0]   offset_ns,
  output logic            offset_valid
);
  logic [TW-1:0] cap_arr [NP];
  logic [NP-1:0] hit;

  drift_timer #(.TW(TW), .SW(SW), .CW(CW), .NORM(NORM_STEP)) u_timer (
    .clk(clk), .rst(rst), .period(cfg_period), .alt_step(cfg_alt_step),
    .load(comp_load), .load_cnt(comp_ticks),
    .now_q(now_ns), .wrap_q(cycle_start), .busy(comp_busy)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    sfd_hunt u_hunt (
      .clk(clk), .rst(rst), .rx_valid(rx_valid[p]),
      .rx_byte(rx_byte[8*p +: 8]), .sfd_hit(hit[p])
    );
    ts_capture #(.TW(TW)) u_cap (
      .clk(clk), .rst(rst), .hit(hit[p]), .clear(cap_clear[p]),
      .now(now_ns), .cap_q(cap_arr[p]),
      .full_q(cap_full[p]), .ovr_q(cap_overrun[p])
    );
    assign cap_ns[TW*p +: TW] = cap_arr[p];
  end

  logic signed [TW:0] diff;
  assign diff = $signed({1'b0, cap_arr[off_port]}) - $signed({1'b0, exp_time});

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_ns    <= '0;
      offset_valid <= 1'b0;
    end else begin
      offset_valid <= exp_wr;
      if (exp_wr) offset_ns <= OW'(diff);
    end
  end
endmodule

// File: rtl/sfd_ts_sync_chk.sv
module sfd_ts_sync_chk #(
  parameter int NP   = 2,
  parameter int TW   = 32,
  parameter int SW   = 4,
  parameter int NORM = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [TW-1:0]    cfg_period,
  input logic [SW-1:0]    cfg_alt_step,
  input logic [NP-1:0]    cap_clear,
  input logic             exp_wr,
  input logic [TW-1:0]    now_ns,
  input logic             cycle_start,
  input logic             comp_busy,
  input logic [TW*NP-1:0] cap_ns,
  input logic [NP-1:0]    cap_full,
  input logic [NP-1:0]    cap_overrun,
  input logic             offset_valid
);
  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (!comp_busy && ((TW+1)'(now_ns) + (TW+1)'(NORM) < (TW+1)'(cfg_period)))
      |=> (now_ns == $past(now_ns) + TW'(NORM))); // R2

  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> (now_ns < $past(now_ns))); // R2

  AST_ALT_STEP: assert property (@(posedge clk) disable iff (rst)
    (comp_busy && ((TW+1)'(now_ns) + (TW+1)'(cfg_alt_step) < (TW+1)'(cfg_period)))
      |=> (now_ns == $past(now_ns) + TW'($past(cfg_alt_step)))); // R3

  AST_OFFSET_PULSE: assert property (@(posedge clk) disable iff (rst)
    exp_wr |=> offset_valid); // R9

  AST_OFFSET_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    !exp_wr |=> !offset_valid); // R9

  for (genvar g = 0; g < NP; g++) begin : g_slot
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cap_full[g] && !cap_clear[g]) |=> $stable(cap_ns[TW*g +: TW])); // R8

    AST_OVR_IMPLIES_FULL: assert property (@(posedge clk) disable iff (rst)
      cap_overrun[g] |-> cap_full[g]); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (cap_clear[g] && !cap_full[g]) |=> !cap_overrun[g]); // R7
  end
endmodule

bind sfd_ts_sync sfd_ts_sync_chk #(.NP(NP), .TW(TW), .SW(SW), .NORM(NORM_STEP)) u_chk (
  .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_alt_step(cfg_alt_step),
  .cap_clear(cap_clear), .exp_wr(exp_wr), .now_ns(now_ns),
  .cycle_start(cycle_start), .comp_busy(comp_busy), .cap_ns(cap_ns),
  .cap_full(cap_full), .cap_overrun(cap_overrun), .offset_valid(offset_valid)
);

// File: tb/sfd_ts_sync_test.sv
`timescale 1ns/1ps
module sfd_ts_sync_test;
  localparam int CLK_NS = 10;
  localparam int NP = 2;
  localparam int TW = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [TW-1:0]     cfg_period = 32'd100;
  logic [3:0]        cfg_alt_step = 4'd4;
  logic              comp_load = 1'b0;
  logic [15:0]       comp_ticks = 16'd0;
  logic [NP-1:0]     rx_valid = '0;
  logic [8*NP-1:0]   rx_byte = '0;
  logic [NP-1:0]     cap_clear = '0;
  logic [0:0]        off_port = 1'b0;
  logic              exp_wr = 1'b0;
  logic [TW-1:0]     exp_time = '0;
  logic [TW-1:0]     now_ns;
  logic              cycle_start, comp_busy, offset_valid;
  logic [TW*NP-1:0]  cap_ns;
  logic [NP-1:0]     cap_full, cap_overrun;
  logic [31:0]       offset_ns;

  sfd_ts_sync uut (
    .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_alt_step(cfg_alt_step),
    .comp_load(comp_load), .comp_ticks(comp_ticks), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .cap_clear(cap_clear), .off_port(off_port),
    .exp_wr(exp_wr), .exp_time(exp_time), .now_ns(now_ns),
    .cycle_start(cycle_start), .comp_busy(comp_busy), .cap_ns(cap_ns),
    .cap_full(cap_full), .cap_overrun(cap_overrun), .offset_ns(offset_ns),
    .offset_valid(offset_valid)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int unsigned ref_t = 0;
  int unsigned ref_cnt = 0;
  bit ref_cs = 1'b0;
  logic [7:0] fr [0:9];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    int unsigned step, s;
    @(posedge clk);
    step = (ref_cnt != 0) ? int'(cfg_alt_step) : 5;
    s = ref_t + step;
    ref_cs = 1'b0;
    if (s >= cfg_period) begin
      s = s - cfg_period;
      ref_cs = 1'b1;
    end
    ref_t = s;
    if (comp_load) ref_cnt = comp_ticks;
    else if (ref_cnt != 0) ref_cnt = ref_cnt - 1;
    @(negedge clk);
    check(now_ns == ref_t, "R2/R3", "timer", now_ns, ref_t);
    check(cycle_start == ref_cs, "R2", "cycle_start", cycle_start, ref_cs);
    check(comp_busy == (ref_cnt != 0), "R3", "comp_busy", comp_busy, ref_cnt != 0);
  endtask

  task automatic do_reset(input int unsigned period);
    cfg_period = period;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(now_ns == 0 && cycle_start == 0 && comp_busy == 0, "R1", "timer reset",
          now_ns, 0);
    check(cap_full == 0 && cap_overrun == 0 && offset_valid == 0, "R1", "flags reset",
          {cap_full, cap_overrun, offset_valid}, 0);
    rst = 1'b0;
    ref_t = 0;
    ref_cnt = 0;
  endtask

  task automatic send(input int p, input int len, input int hit_at, input int clr_at,
                      output int unsigned cap_exp);
    cap_exp = 0;
    for (int i = 0; i < len; i++) begin
      rx_valid[p] = 1'b1;
      rx_byte[p*8 +: 8] = fr[i];
      cap_clear[p] = (i == clr_at);
      if (i == hit_at) cap_exp = ref_t;
      tick();
    end
    rx_valid[p] = 1'b0;
    cap_clear[p] = 1'b0;
    tick();
  endtask

  task automatic clear_port(input int p);
    cap_clear[p] = 1'b1;
    tick();
    cap_clear[p] = 1'b0;
  endtask

  task automatic offset_probe(input int p, input int unsigned cap_v, input int unsigned e);
    longint expv;
    off_port = p[0:0];
    exp_time = e;
    exp_wr = 1'b1;
    tick();
    exp_wr = 1'b0;
    expv = longint'(cap_v) - longint'(e);
    check(offset_valid == 1'b1, "R9", "offset_valid high", offset_valid, 1);
    check(longint'($signed(offset_ns)) == expv, "R9", "offset value",
          longint'($signed(offset_ns)), expv);
    tick();
    check(offset_valid == 1'b0, "R9", "offset_valid one clock", offset_valid, 0);
    check(longint'($signed(offset_ns)) == expv, "R9", "offset held",
          longint'($signed(offset_ns)), expv);
  endtask

  initial begin
    int unsigned pers [4] = '{40, 55, 100, 10000};
    int unsigned e0, e1, en, keep;

    // R1 and R2: reset state and plain stepping over several periods
    foreach (pers[k]) begin
      do_reset(pers[k]);
      repeat (3 * pers[k] / 5 + 7) tick();
    end

    // R3: every alternate step with several tick counts
    do_reset(100);
    for (int a = 0; a < 16; a++) begin
      for (int n = 1; n <= 5; n += 2) begin
        cfg_alt_step = a[3:0];
        comp_ticks = n[15:0];
        comp_load = 1'b1;
        tick();
        comp_load = 1'b0;
        repeat (n + 2) tick();
      end
    end
    // R3: reload while busy restarts the count
    cfg_alt_step = 4'd6;
    comp_ticks = 16'd6;
    comp_load = 1'b1; tick(); comp_load = 1'b0;
    repeat (2) tick();
    comp_ticks = 16'd2;
    comp_load = 1'b1; tick(); comp_load = 1'b0;
    repeat (5) tick();

    // Capture tests
    do_reset(10000);
    repeat (600) tick();

    // R4: delimiter at byte index 2
    fr = '{8'h55, 8'h55, 8'hD5, 8'hAA, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send(0, 4, 2, -1, e0);
    check(cap_full == 2'b01, "R4", "full after delimiter", cap_full, 1);
    check(cap_ns[31:0] == e0, "R4", "captured time", cap_ns[31:0], e0);
    check(cap_overrun == 2'b00, "R4", "no overrun", cap_overrun, 0);

    // R5: first byte is the delimiter
    fr = '{8'hD5, 8'h55, 8'hD5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send(1, 3, -1, -1, en);
    check(cap_full[1] == 1'b0, "R5", "no capture, delimiter first", cap_full[1], 0);
    // R5: bad byte after preamble
    fr = '{8'h55, 8'hAA, 8'hD5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send(1, 3, -1, -1, en);
    check(cap_full[1] == 1'b0, "R5", "no capture after abort", cap_full[1], 0);
    // R5: valid gap restarts the hunt
    fr = '{8'h55, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send(1, 1, -1, -1, en);
    fr = '{8'hD5, 8'h55, 8'hD5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send(1, 3, -1, -1, en);
    check(cap_full[1] == 1'b0, "R5", "no capture across gap", cap_full[1], 0);

    // R4 and R6: long preamble on port 1, port 0 untouched
    fr = '{8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'hD5, 8'h11, 8'h00};
    send(1, 9, 7, -1, e1);
    check(cap_full == 2'b11, "R4", "port 1 full", cap_full, 3);
    check(cap_ns[63:32] == e1, "R4", "port 1 time", cap_ns[63:32], e1);
    check(cap_ns[31:0] == e0, "R6", "port 0 unchanged", cap_ns[31:0], e0);

    // R8 and R6: second delimiter on full port 0
    fr = '{8'h55, 8'hD5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send(0, 2, -1, -1, en);
    check(cap_overrun[0] == 1'b1, "R8", "overrun set", cap_overrun[0], 1);
    check(cap_ns[31:0] == e0, "R8", "value held on overrun", cap_ns[31:0], e0);
    check(cap_overrun[1] == 1'b0 && cap_ns[63:32] == e1, "R6", "port 1 unaffected",
          cap_overrun[1], 0);

    // R9: offset sweep on both ports, positive and negative
    for (int k = -3; k <= 3; k++) begin
      offset_probe(0, e0, int'(e0) + k * 40 + 7);
      offset_probe(1, e1, int'(e1) - k * 1000);
    end
    offset_probe(0, e0, e0 - 50);

    // R7 and R8: clear empties the slot and drops the overrun flag
    clear_port(0);
    tick();
    check(cap_full[0] == 1'b0, "R7", "full cleared", cap_full[0], 0);
    check(cap_overrun[0] == 1'b0, "R8", "overrun cleared", cap_overrun[0], 0);
    check(cap_full[1] == 1'b1, "R6", "port 1 still full", cap_full[1], 1);

    // R7: fresh capture after clear
    fr = '{8'h55, 8'hD5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send(0, 2, 1, -1, keep);
    check(cap_full[0] == 1'b1 && cap_ns[31:0] == keep, "R7", "recapture",
          cap_ns[31:0], keep);

    // R7: clear and delimiter in the same clock store the new value
    send(0, 2, 1, 1, en);
    check(cap_full[0] == 1'b1, "R7", "full after same-clock clear", cap_full[0], 1);
    check(cap_ns[31:0] == en, "R7", "new value on same-clock clear", cap_ns[31:0], en);
    check(cap_overrun[0] == 1'b0, "R7", "no overrun on same-clock clear",
          cap_overrun[0], 0);

    // R5: only the first delimiter of a frame captures
    clear_port(1);
    fr = '{8'h55, 8'hD5, 8'h00, 8'hD5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send(1, 4, 1, -1, e1);
    check(cap_ns[63:32] == e1, "R5", "first delimiter kept", cap_ns[63:32], e1);
    check(cap_overrun[1] == 1'b0, "R5", "later delimiter ignored", cap_overrun[1], 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule